// File: doc/BRIEF.md
# Single-Bus Datapath with Stack-Frame Link Sequencer

This block is a small processor core in which every register transfer travels over one shared internal bus. A hardwired step sequencer drives the datapath through a compact strobe bundle. Each instruction starts with a word fetch from memory. It then runs a stack-frame link: the stack pointer (address register 7) drops by one word, the chosen address register is pushed at the new stack top, that register takes a copy of the stack pointer, and a signed 16-bit displacement from the instruction is added to the stack pointer.

The ALU has two inputs. The first is the bus itself. The second comes from a selector that picks the Y latch or one of the constants 0, 1, 2 and 4. The ALU can add, or subtract in the direction "bus minus selected operand", and its result is held in a Z latch. Memory is reached through an address register (MAR) and a data register (MDR), with a simple request/complete handshake. A wait-for-completion step holds the sequencer until memory reports that the access is finished.

Top module: `link_core`

## Requirements
- R1: In every control step at most one source drives the internal bus, and at most one address register has its bus output enabled.
- R2: Each instruction is fetched by a memory read at the current PC. The PC then advances by 4, and the returned word is latched into the IR. The IR holds the register index in bits [18:16] and the displacement in bits [15:0]. All other bits are ignored, and every fetched word executes as a link.
- R3: A link first lowers the stack pointer (A7) by 4, then writes the selected register's value to memory at the lowered address.
- R4: After the push, the selected register holds the lowered stack pointer. For index 7, the pushed value is the lowered stack pointer.
- R5: The stack pointer finally becomes the lowered value plus the sign-extended displacement. Negative, zero and positive displacements are all supported.
- R6: Only one memory request is outstanding at a time, and read and write are never asserted together. Address, write data and the request level stay unchanged until the memory signals completion.
- R7: The sequencer stalls in a wait step until completion, for any latency. One instruction takes exactly 7 + 2*L cycles when each access completes after L cycles.
- R8: The last link step asserts `instrDone` for one cycle. The very next step is the fetch of the following instruction, at the updated PC.
- R9: After reset, no memory request is active, the first fetch reads address RESET_PC, A7 holds STACK_TOP, and every other register Ai holds the value i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 32 | Byte address from MAR |
| memWdata | output | 32 | Write data from MDR |
| memRdata | input | 32 | Read data from memory |
| memRead | output | 1 | Read request, held until completion |
| memWrite | output | 1 | Write request, held until completion |
| memDone | input | 1 | One-cycle completion pulse from memory |
| instrDone | output | 1 | High during the final step of each instruction |

## Verification
A twelve-instruction program is run at each memory latency from 1 to 4. The program covers every register index, including index 7 (the stack pointer itself) and index 6 more than once, with displacements of -8, -4, 0, +4, +12 and +16.

Later pushes of registers written by earlier links make those registers' values visible as memory write data. This separates a wrong copy of the stack pointer (R4) from a wrong displacement sum (R5), which shows up instead in the following push address. The index-7 case tells apart the order of decrement and push.

Sweeping the latency separates the stall logic (R7 cycle counts) from request holding (R6, where the address is compared at request start and at completion). Fetch addresses confirm the PC advance and the return to fetch after each instruction.

// File: rtl/link_pkg.sv
package link_pkg;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_PC, BUS_Z, BUS_MDR, BUS_REG, BUS_OFF
  } busSrcT;

  typedef enum logic [2:0] {
    K_Y, K_0, K_1, K_2, K_4
  } kSelT;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_E1, S_E2, S_E3, S_E4, S_E5, S_E6
  } stepT;

  // strobe bundle from sequencer to datapath
  typedef struct packed {
    busSrcT busSrc;
    logic   regOutSp;  // register read port: 1 = stack pointer, 0 = IR field
    logic   regInSp;   // register write port: 1 = stack pointer, 0 = IR field
    logic   regIn;
    logic   pcIn;
    logic   irIn;
    logic   zIn;
    logic   yIn;
    logic   marIn;
    logic   mdrIn;
    logic   aluSub;
    kSelT   kSel;
    logic   memRd;
    logic   memWr;
    logic   wmfc;
    logic   endStep;
  } ctlT;

endpackage

// File: rtl/link_ctl.sv
module link_ctl
  import link_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic memBusy,
  output ctlT  ctl,
  output logic instrDone
);

  stepT step;
  logic stall;

  assign stall     = ctl.wmfc & memBusy;
  assign instrDone = ctl.endStep;

  always_comb begin
    ctl = '0;
    ctl.busSrc = BUS_NONE;
    ctl.kSel   = K_0;
    unique case (step)
      S_F1: begin  // MAR <- PC, start read, Z <- PC + 4
        ctl.busSrc = BUS_PC;
        ctl.marIn  = 1'b1;
        ctl.memRd  = 1'b1;
        ctl.kSel   = K_4;
        ctl.zIn    = 1'b1;
      end
      S_F2: begin  // PC <- Z, wait for read
        ctl.busSrc = BUS_Z;
        ctl.pcIn   = 1'b1;
        ctl.wmfc   = 1'b1;
      end
      S_F3: begin  // IR <- MDR
        ctl.busSrc = BUS_MDR;
        ctl.irIn   = 1'b1;
      end
      S_E1: begin  // Z <- SP - 4
        ctl.busSrc   = BUS_REG;
        ctl.regOutSp = 1'b1;
        ctl.kSel     = K_4;
        ctl.aluSub   = 1'b1;
        ctl.zIn      = 1'b1;
      end
      S_E2: begin  // SP <- Z, MAR <- Z
        ctl.busSrc  = BUS_Z;
        ctl.regIn   = 1'b1;
        ctl.regInSp = 1'b1;
        ctl.marIn   = 1'b1;
      end
      S_E3: begin  // MDR <- Ar
        ctl.busSrc = BUS_REG;
        ctl.mdrIn  = 1'b1;
      end
      S_E4: begin  // start write, Ar <- SP, Y <- SP
        ctl.busSrc   = BUS_REG;
        ctl.regOutSp = 1'b1;
        ctl.regIn    = 1'b1;
        ctl.yIn      = 1'b1;
        ctl.memWr    = 1'b1;
      end
      S_E5: begin  // Z <- offset + Y, wait for write
        ctl.busSrc = BUS_OFF;
        ctl.kSel   = K_Y;
        ctl.zIn    = 1'b1;
        ctl.wmfc   = 1'b1;
      end
      S_E6: begin  // SP <- Z, end
        ctl.busSrc  = BUS_Z;
        ctl.regIn   = 1'b1;
        ctl.regInSp = 1'b1;
        ctl.endStep = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            step <= S_F1;
    else if (stall)       step <= step;
    else if (ctl.endStep) step <= S_F1;
    else                  step <= stepT'(step + 4'd1);
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(step));

  p_end_refetch_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.endStep |=> (step == S_F1));

endmodule

// File: rtl/link_dp.sv
module link_dp
  import link_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          REG_CNT   = 8,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] RESET_PC  = 32'h0,
  parameter logic [31:0] STACK_TOP = 32'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  output logic              memBusy,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRead,
  output logic              memWrite,
  input  logic              memDone
);

  localparam int IDX_W  = $clog2(REG_CNT);
  localparam int IR_W   = OFF_W + IDX_W;
  localparam int SP_IDX = REG_CNT - 1;

  logic [DATA_W-1:0] pc, y, z, mar, mdr, bus, kVal, aluOut, offExt;
  logic [IR_W-1:0]   ir;
  logic [IDX_W-1:0]  irIdx, outIdx, inIdx;
  logic [DATA_W-1:0] aReg [REG_CNT];
  logic [REG_CNT-1:0] regOe, regWe;
  logic rdPend, wrPend;

  // instruction field decode
  assign irIdx  = ir[IR_W-1:OFF_W];
  assign offExt = {{(DATA_W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  assign outIdx = ctl.regOutSp ? IDX_W'(SP_IDX) : irIdx;
  assign inIdx  = ctl.regInSp  ? IDX_W'(SP_IDX) : irIdx;

  // address register file with per-register enables
  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    assign regOe[i] = (ctl.busSrc == BUS_REG) && (outIdx == IDX_W'(i));
    assign regWe[i] = ctl.regIn && (inIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)         aReg[i] <= (i == SP_IDX) ? STACK_TOP : DATA_W'(i);
      else if (regWe[i]) aReg[i] <= bus;
    end
  end

  // internal bus
  always_comb begin
    bus = '0;
    unique case (ctl.busSrc)
      BUS_PC:  bus = pc;
      BUS_Z:   bus = z;
      BUS_MDR: bus = mdr;
      BUS_OFF: bus = offExt;
      BUS_REG: for (int i = 0; i < REG_CNT; i++) if (regOe[i]) bus = aReg[i];
      default: bus = '0;
    endcase
  end

  // operand selector and ALU
  always_comb begin
    unique case (ctl.kSel)
      K_Y:     kVal = y;
      K_1:     kVal = DATA_W'(1);
      K_2:     kVal = DATA_W'(2);
      K_4:     kVal = DATA_W'(4);
      default: kVal = '0;
    endcase
  end
  assign aluOut = ctl.aluSub ? (bus - kVal) : (bus + kVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= RESET_PC;
      ir <= '0;
      y  <= '0;
      z  <= '0;
      mar <= '0;
    end else begin
      if (ctl.pcIn)  pc  <= bus;
      if (ctl.irIn)  ir  <= bus[IR_W-1:0];
      if (ctl.yIn)   y   <= bus;
      if (ctl.zIn)   z   <= aluOut;
      if (ctl.marIn) mar <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  mdr <= '0;
    else if (ctl.mdrIn)         mdr <= bus;
    else if (rdPend && memDone) mdr <= memRdata;
  end

  // memory request tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else begin
      if (ctl.memRd)    rdPend <= 1'b1;
      else if (memDone) rdPend <= 1'b0;
      if (ctl.memWr)    wrPend <= 1'b1;
      else if (memDone) wrPend <= 1'b0;
    end
  end

  assign memBusy  = (rdPend | wrPend) & ~memDone;
  assign memAddr  = mar;
  assign memWdata = mdr;
  assign memRead  = rdPend;
  assign memWrite = wrPend;

  p_one_reg_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regOe));

  p_no_dual_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPend && wrPend));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((rdPend || wrPend) && !memDone) |=>
      ($stable(mar) && $stable(mdr) && (rdPend || wrPend)));

  p_no_wait_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memRd || ctl.memWr) |-> !(rdPend || wrPend));

endmodule

// File: rtl/link_core.sv
module link_core
  import link_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          REG_CNT   = 8,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] RESET_PC  = 32'h0,
  parameter logic [31:0] STACK_TOP = 32'h400
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRead,
  output logic              memWrite,
  input  logic              memDone,
  output logic              instrDone
);

  ctlT  ctl;
  logic memBusy;

  link_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .memBusy   (memBusy),
    .ctl       (ctl),
    .instrDone (instrDone)
  );

  link_dp #(
    .DATA_W    (DATA_W),
    .REG_CNT   (REG_CNT),
    .OFF_W     (OFF_W),
    .RESET_PC  (RESET_PC),
    .STACK_TOP (STACK_TOP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memBusy  (memBusy),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memRead  (memRead),
    .memWrite (memWrite),
    .memDone  (memDone)
  );

endmodule

// File: tb/sim_link_core.sv
module sim_link_core;

  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memRead, memWrite, memDone, instrDone;

  always #5 clk = ~clk;

  link_core u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRead(memRead), .memWrite(memWrite),
    .memDone(memDone), .instrDone(instrDone)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] mem [256];
  int          progReg [N] = '{6, 0, 3, 7, 1, 2, 4, 5, 6, 7, 0, 6};
  int          progDisp[N] = '{-8, -8, 12, 0, -4, -8, 4, -8, -8, 0, 16, -8};
  logic [31:0] expWA [N];
  logic [31:0] expWD [N];

  int lat = 1;
  int cnt, fIdx, wIdx, dIdx, cyc, lastCyc;
  logic [31:0] reqAddr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (latency %0d)", req, act, exp, lat);
    end
  endtask

  // reference model of the program effect
  task automatic buildModel();
    logic [31:0] sp;
    logic [31:0] a [8];
    sp = 32'h400;
    for (int i = 0; i < 8; i++) a[i] = 32'(i);
    for (int k = 0; k < N; k++) begin
      sp = sp - 32'd4;
      expWA[k] = sp;
      if (progReg[k] == 7) expWD[k] = sp;
      else begin
        expWD[k] = a[progReg[k]];
        a[progReg[k]] = sp;
      end
      sp = sp + 32'(progDisp[k]);
    end
  endtask

  // memory model with latency, plus monitors
  always @(negedge clk) begin
    if (!rstN) begin
      memDone = 1'b0;
      cnt = 0;
    end else begin
      cyc++;
      if (instrDone) begin
        if (dIdx >= 1) check("R7 cycles per instruction", 32'(cyc - lastCyc), 32'(7 + 2 * lat));
        lastCyc = cyc;
        dIdx++;
      end
      if (memDone) memDone = 1'b0;
      else if (memRead || memWrite) begin
        if (cnt == 0) reqAddr = memAddr;
        cnt++;
        if (cnt >= lat) begin
          check("R6 address held", memAddr, reqAddr);
          if (memRead) begin
            if (fIdx < N) check(fIdx == 0 ? "R9 first fetch" : "R2/R8 fetch address",
                                memAddr, 32'(4 * fIdx));
            fIdx++;
            memRdata = mem[memAddr[9:2]];
          end else begin
            if (wIdx < N) begin
              check("R3/R5 push address", memAddr, expWA[wIdx]);
              check("R1/R4 push data", memWdata, expWD[wIdx]);
            end
            wIdx++;
            mem[memAddr[9:2]] = memWdata;
          end
          memDone = 1'b1;
          cnt = 0;
        end
      end
    end
  end

  initial begin
    memDone  = 1'b0;
    memRdata = '0;
    buildModel();
    for (int l = 1; l <= 4; l++) begin
      rstN = 1'b0;
      lat = l;
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      // upper bits set to check they are ignored
      for (int k = 0; k < N; k++)
        mem[k] = {13'h1ABC, 3'(progReg[k]), 16'(progDisp[k])};
      fIdx = 0; wIdx = 0; dIdx = 0; cyc = 0; lastCyc = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 no read in reset", {31'b0, memRead}, 32'd0);
      check("R9 no write in reset", {31'b0, memWrite}, 32'd0);
      rstN = 1'b1;
      for (int t = 0; t < 3000 && dIdx < N; t++) @(posedge clk);
      if (dIdx < N) begin
        total++;
        bad++;
        $display("FAIL R8 watchdog: actual=%0d expected=%0d instructions", dIdx, N);
      end
      @(negedge clk);
      check("R3 push count", 32'(wIdx), 32'(N));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule